// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between a bus protocol controller and the driver stage of a differential bus transceiver. It watches the serial transmit bit, where a low level is a dominant bit and a high level is recessive. While the interface is in its active mode, the block counts how many consecutive clock cycles the bit has been low. If that run grows past a programmable limit, the block treats the controller as stuck. It then drops the driver enable, forces the transmit bit it passes on to recessive, and raises a sticky timeout flag.

The fault clears only when the transmit input goes from low back to high. Passing time does not clear it. The receive path is outside this block, so it is unaffected: the node keeps listening to the bus while its transmitter is muted.

The transmit input is asynchronous to the clock. It passes through a two-flop synchronizer whose flops reset high, so a floating or unsupplied input reads as recessive. Leaving active mode disables the driver and clears both the count and the latched fault.

Top module: `txd_timeout_guard`

## Requirements
- R1: While `rst_ni` is low, and at the first sample after reset, `timeout_o` is 0 and `txd_o` is 1. `drv_en_o` equals `active_i`. The synchronizer resets to 1 (recessive).
- R2: While the driver is enabled, `txd_o` follows `txd_i` after two clock edges, because of the two-flop synchronizer.
- R3: In active mode, `timeout_o` rises at the clock edge that sees the (limit+1)-th consecutive low synchronized sample. From a recessive idle state, that edge is limit+3 edges after `txd_i` falls.
- R4: Any high synchronized sample restarts the count from zero. A one-cycle high pulse therefore postpones the timeout by a full limit.
- R5: While `timeout_o` is 1, `drv_en_o` is 0 and `txd_o` is forced to 1 (recessive).
- R6: The timeout stays latched while the synchronized input stays low. It clears on the first edge that sees a high synchronized sample following a low one. That edge is three edges after `txd_i` rises.
- R7: When `active_i` is 0, `drv_en_o` is 0 and `txd_o` is 1. At the next edge the timeout latch and the count clear, and no counting happens while the block is inactive. On return to active mode, counting restarts from zero.
- R8: A `limit_i` value of 0 selects the built-in default limit of 50000 cycles, which is 0.5 ms at 100 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| txd_i | input | 1 | Transmit bit from the controller (0 = dominant), asynchronous |
| active_i | input | 1 | Interface is in active (normal) mode |
| limit_i | input | CNT_W | Timeout limit in clock cycles; 0 selects the default |
| txd_o | output | 1 | Gated transmit bit toward the driver |
| drv_en_o | output | 1 | Driver enable |
| timeout_o | output | 1 | Latched stuck-dominant fault |

## Verification
The assertions assume that `limit_i` is held constant while a low run is being counted, and that `active_i` is synchronous to `clk_i`. The bench changes `limit_i` only while `txd_i` has been high for several cycles. It drives `txd_i` and `active_i` only at falling clock edges. Each check is timed by counting the two synchronizer flops plus the counter stage.

// File: rtl/txg_pkg.sv
package txg_pkg;
  localparam int unsigned TXG_CNT_W       = 20;
  localparam int unsigned TXG_SYNC_STAGES = 2;
  localparam int unsigned TXG_DEF_LIMIT   = 50000; // 0.5 ms at 100 MHz
endpackage

// File: rtl/txg_sync.sv
module txg_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/txg_dom_timer.sv
module txg_dom_timer #(
  parameter int unsigned CNT_W     = 20,
  parameter int unsigned DEF_LIMIT = 50000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             txd_s_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             to_o
);
  localparam logic [CNT_W-1:0] DEF_L = CNT_W'(DEF_LIMIT);

  logic [CNT_W-1:0] cnt_q, lim_eff;
  logic             latch_q, txd_q;

  assign lim_eff = (limit_i == '0) ? DEF_L : limit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      latch_q <= 1'b0;
      txd_q   <= 1'b1;
    end else begin
      txd_q <= txd_s_i;
      if (!active_i) begin
        cnt_q   <= '0;
        latch_q <= 1'b0;
      end else if (txd_s_i) begin
        cnt_q <= '0;
        if (!txd_q) latch_q <= 1'b0; // release only on low-to-high
      end else if (!latch_q) begin
        if (cnt_q == lim_eff) latch_q <= 1'b1;
        else                  cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign to_o = latch_q;

  assert_set_on_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_q) |-> (!$past(txd_s_i) && $past(active_i)));

  assert_high_restarts_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && txd_s_i) |=> (cnt_q == '0));

  assert_release_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(latch_q) |-> (!$past(active_i) || ($past(txd_s_i) && !$past(txd_q))));

  assert_hold_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && active_i && !txd_s_i) |=> latch_q);

  assert_inactive_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (!latch_q && cnt_q == '0));
endmodule

// File: rtl/txg_out_gate.sv
module txg_out_gate (
  input  logic txd_s_i,
  input  logic active_i,
  input  logic to_i,
  output logic txd_o,
  output logic drv_en_o
);
  assign drv_en_o = active_i & ~to_i;
  assign txd_o    = txd_s_i | ~drv_en_o; // recessive when muted
endmodule

// File: rtl/txd_timeout_guard.sv
module txd_timeout_guard
  import txg_pkg::*;
#(
  parameter int unsigned CNT_W       = TXG_CNT_W,
  parameter int unsigned SYNC_STAGES = TXG_SYNC_STAGES,
  parameter int unsigned DEF_LIMIT   = TXG_DEF_LIMIT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             txd_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             txd_o,
  output logic             drv_en_o,
  output logic             timeout_o
);
  logic txd_s, to;

  txg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(txd_i), .q_o(txd_s)
  );

  txg_dom_timer #(.CNT_W(CNT_W), .DEF_LIMIT(DEF_LIMIT)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .txd_s_i(txd_s), .active_i(active_i),
    .limit_i(limit_i), .to_o(to)
  );

  txg_out_gate u_gate (
    .txd_s_i(txd_s), .active_i(active_i), .to_i(to),
    .txd_o(txd_o), .drv_en_o(drv_en_o)
  );

  assign timeout_o = to;

  assert_muted_recessive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (!drv_en_o && txd_o));

  assert_inactive_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (!drv_en_o && txd_o));
endmodule

// File: tb/sim_txd_timeout_guard.sv
`timescale 1ns/1ps
module sim_txd_timeout_guard;
  localparam int unsigned CNT_W = 20;
  localparam int unsigned NV    = 16;

  logic clk = 1'b0, rst_ni = 1'b0, txd = 1'b1, act = 1'b1;
  logic [CNT_W-1:0] limit = 20'd8;
  logic txd_o, drv_en_o, timeout_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  txd_timeout_guard u0 (
    .clk_i(clk), .rst_ni(rst_ni), .txd_i(txd), .active_i(act), .limit_i(limit),
    .txd_o(txd_o), .drv_en_o(drv_en_o), .timeout_o(timeout_o)
  );

  // {txd, active, edges[7:0], exp timeout, exp drv_en, exp txd_o}; limit = 8
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'd4,  3'b011},  // idle
    {1'b0, 1'b1, 8'd10, 3'b010},  // limit+2 edges: not yet
    {1'b0, 1'b1, 8'd1,  3'b101},  // limit+3: fires
    {1'b0, 1'b1, 8'd20, 3'b101},  // held while low
    {1'b1, 1'b1, 8'd2,  3'b101},  // rise still in sync
    {1'b1, 1'b1, 8'd1,  3'b011},  // released
    {1'b0, 1'b1, 8'd6,  3'b010},
    {1'b1, 1'b1, 8'd1,  3'b010},  // one-cycle high pulse
    {1'b0, 1'b1, 8'd9,  3'b010},
    {1'b0, 1'b1, 8'd1,  3'b010},  // restarted count not yet done
    {1'b0, 1'b1, 8'd1,  3'b101},
    {1'b0, 1'b0, 8'd1,  3'b001},  // leave active: clears
    {1'b0, 1'b0, 8'd30, 3'b001},  // no counting inactive
    {1'b0, 1'b1, 8'd8,  3'b010},  // fresh count, sync already low
    {1'b0, 1'b1, 8'd1,  3'b101},
    {1'b1, 1'b1, 8'd3,  3'b011}
  };
  string tag [NV] = '{"R1", "R3", "R3_R5", "R6", "R6", "R6", "R2", "R4", "R4", "R4",
                      "R4_R5", "R7", "R7", "R7", "R7_R3", "R6"};

  task automatic check(input string req, input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset state
    edges(3);
    check("R1", timeout_o, 1'b0, "timeout_o");
    check("R1", drv_en_o, 1'b1, "drv_en_o");
    check("R1", txd_o, 1'b1, "txd_o");
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      txd = VEC[i][12];
      act = VEC[i][11];
      edges(int'(VEC[i][10:3]));
      check(tag[i], timeout_o, VEC[i][2], $sformatf("vec%0d timeout_o", i));
      check(tag[i], drv_en_o,  VEC[i][1], $sformatf("vec%0d drv_en_o", i));
      check(tag[i], txd_o,     VEC[i][0], $sformatf("vec%0d txd_o", i));
    end

    // R2 two-edge synchronizer latency
    edges(4);
    txd = 1'b0;
    edges(1);
    check("R2", txd_o, 1'b1, "txd_o after 1 edge");
    edges(1);
    check("R2", txd_o, 1'b0, "txd_o after 2 edges");
    txd = 1'b1;
    edges(4);

    // R1 reset in the middle of a timeout, then count from scratch (R3)
    txd = 1'b0;
    edges(15);
    check("R5", timeout_o, 1'b1, "timeout before reset");
    rst_ni = 1'b0;
    #1;
    check("R1", timeout_o, 1'b0, "timeout in reset");
    check("R1", txd_o, 1'b1, "txd_o in reset");
    check("R1", drv_en_o, 1'b1, "drv_en_o in reset");
    @(negedge clk);
    rst_ni = 1'b1;
    edges(10);
    check("R3", timeout_o, 1'b0, "post-reset limit+2");
    edges(1);
    check("R3", timeout_o, 1'b1, "post-reset limit+3");
    txd = 1'b1;
    edges(4);
    check("R6", timeout_o, 1'b0, "released after reset test");

    // R8 default limit when limit_i is 0
    limit = '0;
    txd = 1'b0;
    edges(50002);
    check("R8", timeout_o, 1'b0, "default limit+2");
    edges(1);
    check("R8", timeout_o, 1'b1, "default limit+3");
    check("R8", drv_en_o, 1'b0, "default muted");
    txd = 1'b1;
    edges(4);
    check("R8", timeout_o, 1'b0, "default released");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule